// File: doc/BRIEF.md
# I2S Stereo Host Transceiver

This block is the host end of a stereo I2S link to a line-out converter and a line-in converter that share one clock set. It runs on the fast master clock and derives the serial bit clock and the word-select clock from it, then moves 24-bit samples each way. The bit clock is the master clock divided by eight. A frame lasts 64 bit clocks, and each channel takes a 32-bit slot within it.

Outgoing samples are written through a load strobe. They are held until the next frame boundary and then shifted out MSB first, starting one full bit clock after each word-select edge. The rest of each slot is zero. Incoming bits are sampled on the bit-clock rising edge. The left/right pair is presented with a one-cycle valid pulse as each frame closes. A loopback input makes the next frame transmit the pair just received, which gives a passthrough.

Top module: `i2s_host_xcvr`

## Requirements
- R1: `sclk` has a period of 8 master clock cycles. After reset it is low for 4 cycles and then high for 4.
- R2: `ws` is low for the left word and high for the right word, 256 master clocks each. It starts low after reset and changes only in the cycle in which `sclk` falls.
- R3: Each 32-bit-clock half-frame is split into slots 0 to 31, where slot 0 is the first bit clock after a `ws` edge. Bit 23 of the word is sent in slot 1 and bit 0 in slot 24, MSB first. The left word goes out while `ws` is low and the right word while `ws` is high.
- R4: `sd_out` changes only when `sclk` falls and holds steady while `sclk` is high.
- R5: `sd_out` is 0 in slot 0 and in slots 25 to 31 of every half-frame.
- R6: `sd_in` is sampled on the rising edge of `sclk` in slots 1 to 24, MSB first, using the same slot numbering as R3. Values in slot 0 and slots 25 to 31 have no effect on the received words.
- R7: `rx_valid` is high for exactly one master clock, in the cycle in which `ws` returns low. At that point `rx_left` and `rx_right` hold the pair received in the frame just ended. The pulse recurs every 512 master clocks.
- R8: A high `tx_load` stores `tx_left` and `tx_right`. They are first transmitted in the frame that begins after the load, and the frame in progress is not altered.
- R9: If `loopback` is high at a frame boundary, the next frame transmits the pair received in the frame that just ended. If `loopback` is low, the stored transmit pair is sent.
- R10: A synchronous reset zeroes the counter, the transmit words and the receive outputs. After reset the first frame starts with `ws` and `sclk` low and transmits zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; every register runs on it |
| rst | input | 1 | Synchronous active-high reset |
| tx_left | input | 24 | Left sample to send |
| tx_right | input | 24 | Right sample to send |
| tx_load | input | 1 | Stores tx_left/tx_right for the next frame |
| loopback | input | 1 | Sends back the received pair instead of the stored one |
| sd_in | input | 1 | Serial data from the line-in converter |
| sclk | output | 1 | Serial bit clock, mclk/8 |
| ws | output | 1 | Word select, low for left |
| sd_out | output | 1 | Serial data to the line-out converter |
| rx_left | output | 24 | Last received left sample |
| rx_right | output | 24 | Last received right sample |
| rx_valid | output | 1 | One-cycle pulse when a new pair is presented |

## Verification
The transmit path is exercised with two unequal, asymmetric word pairs. This exposes a swapped channel, a reversed bit order, or a slot that is off by one. A load made in the middle of a frame shows whether the frame in progress is protected. The receive path is fed a different pair in every frame, with ones driven into every pad slot and into the delay slot, so any sampling outside slots 1 to 24 corrupts the words. Loopback is switched on for three frames and then off, which separates the passthrough source from the stored pair and checks the handover in both directions.

// File: rtl/i2s_host_xcvr.sv
module i2s_host_xcvr #(
  parameter int DATA_W    = 24,
  parameter int DIV_LOG2  = 3,
  parameter int SLOT_LOG2 = 5
) (
  input  logic              mclk,
  input  logic              rst,
  input  logic [DATA_W-1:0] tx_left,
  input  logic [DATA_W-1:0] tx_right,
  input  logic              tx_load,
  input  logic              loopback,
  input  logic              sd_in,
  output logic              sclk,
  output logic              ws,
  output logic              sd_out,
  output logic [DATA_W-1:0] rx_left,
  output logic [DATA_W-1:0] rx_right,
  output logic              rx_valid
);
  localparam int CW = DIV_LOG2 + SLOT_LOG2 + 1;
  localparam logic [DIV_LOG2-1:0]  RISE_PH  = DIV_LOG2'((1 << (DIV_LOG2 - 1)) - 1);
  localparam logic [SLOT_LOG2-1:0] LAST_BIT = SLOT_LOG2'(DATA_W);

  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] act_l, act_r, pend_l, pend_r, rx_sh, rx_lh;

  wire [SLOT_LOG2-1:0] slot      = cnt[CW-2:DIV_LOG2];
  wire                 in_data   = (slot != '0) && (slot <= LAST_BIT);
  wire                 half_end  = &cnt[CW-2:0];
  wire                 frame_end = &cnt;
  wire                 rise      = cnt[DIV_LOG2-1:0] == RISE_PH;

  assign sclk = cnt[DIV_LOG2-1];
  assign ws   = cnt[CW-1];

  wire [DATA_W-1:0]    tx_word = ws ? act_r : act_l;
  wire [SLOT_LOG2-1:0] bidx    = LAST_BIT - slot;
  assign sd_out = in_data & tx_word[bidx];

  always_ff @(posedge mclk) begin
    if (rst) begin
      cnt      <= '0;
      act_l    <= '0;
      act_r    <= '0;
      pend_l   <= '0;
      pend_r   <= '0;
      rx_sh    <= '0;
      rx_lh    <= '0;
      rx_left  <= '0;
      rx_right <= '0;
      rx_valid <= 1'b0;
    end else begin
      cnt      <= cnt + 1'b1;
      rx_valid <= frame_end;
      if (tx_load) begin
        pend_l <= tx_left;
        pend_r <= tx_right;
      end
      if (rise && in_data)
        rx_sh <= {rx_sh[DATA_W-2:0], sd_in};
      if (half_end && !ws)
        rx_lh <= rx_sh;
      if (frame_end) begin
        rx_left  <= rx_lh;
        rx_right <= rx_sh;
        act_l    <= loopback ? rx_lh : pend_l;
        act_r    <= loopback ? rx_sh : pend_r;
      end
    end
  end
endmodule

// File: rtl/i2s_host_xcvr_chk.sv
module i2s_host_xcvr_chk #(
  parameter int DATA_W    = 24,
  parameter int SLOT_LOG2 = 5
) (
  input logic                 mclk,
  input logic                 rst,
  input logic                 sclk,
  input logic                 ws,
  input logic                 sd_out,
  input logic                 rx_valid,
  input logic [SLOT_LOG2-1:0] slot
);
  AST_WS_ON_SCLK_FALL: assert property (@(posedge mclk) disable iff (rst)
    (ws != $past(ws)) |-> $fell(sclk)); // R2
  AST_SD_STABLE_HIGH: assert property (@(posedge mclk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(sd_out)); // R4
  AST_PAD_ZERO: assert property (@(posedge mclk) disable iff (rst)
    ((slot == '0) || (slot > SLOT_LOG2'(DATA_W))) |-> !sd_out); // R5
  AST_VALID_SINGLE: assert property (@(posedge mclk) disable iff (rst)
    rx_valid |=> !rx_valid); // R7
  AST_VALID_AT_LEFT: assert property (@(posedge mclk) disable iff (rst)
    $rose(rx_valid) |-> $fell(ws)); // R7
  AST_SCLK_HIGH_HOLD: assert property (@(posedge mclk) disable iff (rst)
    $rose(sclk) |=> sclk); // R1
endmodule

bind i2s_host_xcvr i2s_host_xcvr_chk #(.DATA_W(DATA_W), .SLOT_LOG2(SLOT_LOG2)) u_chk (
  .mclk(mclk), .rst(rst), .sclk(sclk), .ws(ws), .sd_out(sd_out),
  .rx_valid(rx_valid), .slot(slot)
);

// File: tb/tb_i2s_host_xcvr.sv
module tb_i2s_host_xcvr;
  logic        mclk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] tx_left = '0, tx_right = '0;
  logic        tx_load = 1'b0, loopback = 1'b0, sd_in = 1'b0;
  logic        sclk, ws, sd_out, rx_valid;
  logic [23:0] rx_left, rx_right;

  i2s_host_xcvr dut (
    .mclk(mclk), .rst(rst), .tx_left(tx_left), .tx_right(tx_right),
    .tx_load(tx_load), .loopback(loopback), .sd_in(sd_in), .sclk(sclk),
    .ws(ws), .sd_out(sd_out), .rx_left(rx_left), .rx_right(rx_right),
    .rx_valid(rx_valid)
  );

  always #10 mclk = ~mclk;

  localparam logic [23:0] PAT_A_L = 24'hA5F00F, PAT_A_R = 24'h5A0FF3;
  localparam logic [23:0] PAT_B_L = 24'h800001, PAT_B_R = 24'h3C96E7;

  int errors = 0, checks = 0, k = 0;
  bit run = 0, done = 0;
  int sclk_err = 0, ws_err = 0, pad_err = 0, stab_err = 0;
  logic last_sd = 1'b0;
  logic [23:0] txl [16], txr [16];
  int nv = 0;
  int vk [16];
  logic [23:0] vl [16], vr [16];
  logic vws [16];

  function automatic logic [23:0] rxpat(int f, int h);
    return 24'((f + 1) * 32'h00C35A97 + h * 32'h0005A5A5);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge mclk) if (run) k <= k + 1;

  initial begin
    forever begin
      @(negedge mclk);
      if (run) begin
        automatic int ph = k % 8, s = (k / 8) % 32, h = (k / 256) % 2, f = k / 512;
        automatic logic [23:0] w = rxpat(f, h);
        if (sclk !== (ph >= 4)) sclk_err++;
        if (ws !== h[0]) ws_err++;
        if (ph == 4) begin
          last_sd = sd_out;
          if (s >= 1 && s <= 24) begin
            if (f < 16) begin
              if (h == 0) txl[f][24-s] = sd_out;
              else        txr[f][24-s] = sd_out;
            end
          end else if (sd_out !== 1'b0) pad_err++;
        end else if (ph > 4 && sd_out !== last_sd) stab_err++;
        if (rx_valid && nv < 16) begin
          vk[nv] = k; vl[nv] = rx_left; vr[nv] = rx_right; vws[nv] = ws;
          nv++;
        end
        sd_in = (s >= 1 && s <= 24) ? w[24-s] : 1'b1;
      end
    end
  end

  task automatic wait_k(int n);
    while (k < n) @(negedge mclk);
  endtask

  task automatic load(logic [23:0] l, logic [23:0] r);
    @(negedge mclk);
    tx_left = l; tx_right = r; tx_load = 1'b1;
    @(negedge mclk);
    tx_load = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge mclk);
    check(sclk === 1'b0 && ws === 1'b0, "R10 clocks low in reset", {sclk, ws}, 0);
    check(sd_out === 1'b0 && rx_valid === 1'b0, "R10 data low in reset", {sd_out, rx_valid}, 0);
    check(rx_left === '0 && rx_right === '0, "R10 rx words zero", rx_left ^ rx_right, 0);
    rst = 1'b0; k = 0; run = 1;
  endtask

  task automatic t_clocks;
    check(sclk_err == 0, "R1 sclk waveform", sclk_err, 0);
    check(ws_err == 0, "R2 ws waveform", ws_err, 0);
    check(stab_err == 0, "R4 sd_out steady while sclk high", stab_err, 0);
    check(pad_err == 0, "R5 pad slots zero", pad_err, 0);
  endtask

  task automatic t_tx_hold;
    check(txl[0] == '0 && txr[0] == '0, "R10 first frame zeros", {txl[0][15:0], txr[0][15:0]}, 0);
    check(txl[1] == PAT_A_L, "R8 left after load", txl[1], PAT_A_L);
    check(txr[1] == PAT_A_R, "R8 right after load", txr[1], PAT_A_R);
  endtask

  task automatic t_tx_serial;
    check(txl[2] == PAT_B_L, "R3 left word", txl[2], PAT_B_L);
    check(txr[2] == PAT_B_R, "R3 right word", txr[2], PAT_B_R);
    check(txl[3] == PAT_B_L && txr[3] == PAT_B_R, "R3 repeat frame", txl[3], PAT_B_L);
  endtask

  task automatic t_rx;
    check(nv >= 7, "R7 valid pulses", nv, 7);
    for (int i = 0; i < 7; i++) begin
      check(vk[i] == 512 * (i + 1), "R7 valid timing", vk[i], 512 * (i + 1));
      check(vws[i] == 1'b0, "R7 ws low at valid", vws[i], 0);
      check(vl[i] == rxpat(i, 0), "R6 rx left", vl[i], rxpat(i, 0));
      check(vr[i] == rxpat(i, 1), "R6 rx right", vr[i], rxpat(i, 1));
    end
  endtask

  task automatic t_loop;
    for (int f = 4; f < 7; f++) begin
      check(txl[f] == rxpat(f - 1, 0), "R9 loop left", txl[f], rxpat(f - 1, 0));
      check(txr[f] == rxpat(f - 1, 1), "R9 loop right", txr[f], rxpat(f - 1, 1));
    end
    check(txl[7] == PAT_B_L && txr[7] == PAT_B_R, "R9 stored pair after loop off", txl[7], PAT_B_L);
  endtask

  initial begin
    t_reset;
    wait_k(100);  load(PAT_A_L, PAT_A_R);
    wait_k(600);  load(PAT_B_L, PAT_B_R);
    wait_k(3 * 512 + 100); loopback = 1'b1;
    wait_k(6 * 512 + 100); loopback = 1'b0;
    wait_k(8 * 512 + 20);
    t_clocks;
    t_tx_hold;
    t_tx_serial;
    t_rx;
    t_loop;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule